// File: doc/BRIEF.md
# Sized Compare-and-Swap Memory Unit

This block carries out an atomic compare-and-swap on one memory location. The access can be a byte, a halfword or a word. The pipeline hands it four things: the current value of the compare register, the value of the new-value register, a byte address and a size code. The unit reads the location while holding the memory locked. It zero-extends the loaded value to 32 bits and compares the result with the full 32-bit compare value. It then always writes the location back. On a match it writes the access-sized low part of the new value. On a mismatch it writes the loaded value again.

When the write has been acknowledged, the unit pulses a done strobe. The zero-extended loaded value comes with the strobe, and the pipeline writes it into the compare register. An illegal size code or a misaligned address is rejected at once with an error response, and no memory access takes place. Register-file access and instruction decode are handled outside the block.

Top module: `cas_unit`

## Requirements
- R1: `req_ready` is 1 only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. After a request is taken, `req_ready` stays 0 until the response has been given. After reset, `req_ready` is 1 and `mem_rd`, `mem_wr`, `mem_lock` and `rsp_done` are 0.
- R2: Size code 0 selects a byte, 1 a halfword and 2 a word. Code 3 gets a response with `rsp_err`=1 and `rsp_data`=0, and the memory port never raises `mem_rd` or `mem_wr` for that request.
- R3: A halfword request with address bit 0 set is rejected with `rsp_err`=1 and no memory access. So is a word request whose address bits [1:0] are nonzero. A byte request is legal at any address.
- R4: A legal request makes exactly one read and then exactly one write. Both use the request's address on `mem_addr` and its size code on `mem_size`.
- R5: `rsp_data` is the loaded value zero-extended to 32 bits. Memory data bits above the access size are ignored.
- R6: The comparison uses all 32 bits of the compare value. A compare value with nonzero bits above the access size never matches.
- R7: On a match, `mem_wdata` is the new value masked to the access size, with the upper bits at zero.
- R8: On a mismatch, `mem_wdata` is the zero-extended loaded value.
- R9: `mem_lock` is 1 in every cycle in which `mem_rd` or `mem_wr` is 1, from the read request through the write acknowledge. It is 0 while the unit is idle.
- R10: `rsp_done` is a one-cycle pulse given after the write acknowledge, with `rsp_err`=0. For a rejected request it is given the cycle after acceptance, with `rsp_err`=1.
- R11: `mem_rd` and `mem_wr` are never 1 together. Each stays 1, with the same address, until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the location |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 illegal |
| req_cmp | input | DATA_W | Compare register value (expected value) |
| req_new | input | DATA_W | New-value register value |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Request rejected (illegal size or misaligned) |
| rsp_data | output | DATA_W | Zero-extended loaded value for the compare register |
| mem_rd | output | 1 | Memory read request, held until acknowledge |
| mem_wr | output | 1 | Memory write request, held until acknowledge |
| mem_lock | output | 1 | Memory lock, held from read through write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_size | output | 2 | Access size code on the memory port |
| mem_wdata | output | DATA_W | Write data, right-aligned |
| mem_rdata | input | DATA_W | Read data, right-aligned, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge for the pending read or write |

## Verification
Suppose the stored size or the expected value is corrupted. The first visible sign is `mem_wdata` at the write request, a few cycles after acceptance, and the same request's `rsp_data` confirms it. Suppose instead the sequencer gets into a wrong state. It shows up at once: the lock drops while a read or write is pending, `req_ready` comes back early, or a read or write appears for a request that was rejected. The bench also feeds memory data with junk above the access size. A missing zero-extension therefore shows up in both `rsp_data` and the mismatch write data of that same operation.

// File: rtl/cas_pkg.sv
package cas_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } cas_size_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FAIL,
      ST_READ,
      ST_WRITE,
      ST_DONE
   } cas_state_e;
endpackage

// File: rtl/cas_req_check.sv
module cas_req_check
   import cas_pkg::*;
#(
   parameter bit STRICT_ALIGN = 1'b1
) (
   input  logic [1:0] addr_lo,
   input  cas_size_e  size,
   output logic       fault
);
   logic bad_code;
   logic misaligned;

   assign bad_code = (size == SZ_BAD);

   generate
      if (STRICT_ALIGN) begin : g_strict
         always_comb begin
            case (size)
               SZ_HALF: misaligned = addr_lo[0];
               SZ_WORD: misaligned = |addr_lo;
               default: misaligned = 1'b0;
            endcase
         end
      end else begin : g_relaxed
         assign misaligned = 1'b0;
      end
   endgenerate

   assign fault = bad_code | misaligned;
endmodule

// File: rtl/cas_datapath.sv
module cas_datapath
   import cas_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] req_cmp,
   input  logic [DATA_W-1:0] req_new,
   input  cas_size_e         size,
   input  logic              load_en,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] loaded,
   output logic [DATA_W-1:0] wdata
);
   localparam int BYTE_W = 8;
   localparam int HALF_W = 16;
   localparam logic [DATA_W-1:0] MASK_B = DATA_W'({BYTE_W{1'b1}});
   localparam logic [DATA_W-1:0] MASK_H = DATA_W'({HALF_W{1'b1}});
   localparam logic [DATA_W-1:0] MASK_W = {DATA_W{1'b1}};

   logic [DATA_W-1:0] expect_q;
   logic [DATA_W-1:0] swap_q;
   logic [DATA_W-1:0] load_q;
   logic [DATA_W-1:0] size_mask;
   logic              hit;

   always_comb begin
      case (size)
         SZ_BYTE: size_mask = MASK_B;
         SZ_HALF: size_mask = MASK_H;
         default: size_mask = MASK_W;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expect_q <= '0;
         swap_q   <= '0;
         load_q   <= '0;
      end else begin
         if (capture) begin
            expect_q <= req_cmp;
            swap_q   <= req_new;
         end
         if (load_en)
            load_q <= mem_rdata & size_mask;
      end
   end

   assign hit    = (expect_q == load_q);
   assign loaded = load_q;
   assign wdata  = hit ? (swap_q & size_mask) : load_q;
endmodule

// File: rtl/cas_ctrl.sv
module cas_ctrl
   import cas_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              fault,
   input  logic [ADDR_W-1:0] req_addr,
   input  cas_size_e         req_size,
   input  logic              mem_ack,
   output logic              req_ready,
   output logic              capture,
   output logic              load_en,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_lock,
   output logic [ADDR_W-1:0] addr_q,
   output cas_size_e         size_q,
   output logic              rsp_done,
   output logic              rsp_err
);
   cas_state_e state, state_nx;

   assign req_ready = (state == ST_IDLE);
   assign capture   = req_valid && req_ready;
   assign mem_rd    = (state == ST_READ);
   assign mem_wr    = (state == ST_WRITE);
   assign mem_lock  = mem_rd | mem_wr;
   assign load_en   = mem_rd && mem_ack;
   assign rsp_done  = (state == ST_DONE) || (state == ST_FAIL);
   assign rsp_err   = (state == ST_FAIL);

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:  if (req_valid) state_nx = fault ? ST_FAIL : ST_READ;
         ST_READ:  if (mem_ack) state_nx = ST_WRITE;
         ST_WRITE: if (mem_ack) state_nx = ST_DONE;
         ST_FAIL:  state_nx = ST_IDLE;
         ST_DONE:  state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         addr_q <= '0;
         size_q <= SZ_BYTE;
      end else begin
         state <= state_nx;
         if (capture) begin
            addr_q <= req_addr;
            size_q <= req_size;
         end
      end
   end

   // R9
   lock_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> mem_lock);

   // R11
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr}));

   // R11
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ack) |=> (mem_rd && $stable(addr_q)));

   // R11
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_ack) |=> (mem_wr && $stable(addr_q)));

   // R4
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_ack) |=> mem_wr);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R1
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock || rsp_done) |-> !req_ready);
endmodule

// File: rtl/cas_unit.sv
module cas_unit
   import cas_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter bit STRICT_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_cmp,
   input  logic [DATA_W-1:0] req_new,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_lock,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   initial begin : param_chk
      assert (DATA_W == 32) else $error("cas_unit: DATA_W must be 32");
      assert (ADDR_W >= 2)  else $error("cas_unit: ADDR_W must be at least 2");
   end

   cas_size_e         size_in;
   cas_size_e         size_q;
   logic              fault;
   logic              capture;
   logic              load_en;
   logic [DATA_W-1:0] loaded;

   assign size_in = cas_size_e'(req_size);

   cas_req_check #(.STRICT_ALIGN(STRICT_ALIGN)) u_check (
      .addr_lo (req_addr[1:0]),
      .size    (size_in),
      .fault   (fault)
   );

   cas_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .fault     (fault),
      .req_addr  (req_addr),
      .req_size  (size_in),
      .mem_ack   (mem_ack),
      .req_ready (req_ready),
      .capture   (capture),
      .load_en   (load_en),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_lock  (mem_lock),
      .addr_q    (mem_addr),
      .size_q    (size_q),
      .rsp_done  (rsp_done),
      .rsp_err   (rsp_err)
   );

   cas_datapath #(.DATA_W(DATA_W)) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .req_cmp   (req_cmp),
      .req_new   (req_new),
      .size      (size_q),
      .load_en   (load_en),
      .mem_rdata (mem_rdata),
      .loaded    (loaded),
      .wdata     (mem_wdata)
   );

   assign mem_size = size_q;
   assign rsp_data = (rsp_done && !rsp_err) ? loaded : '0;

   // R2
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_size == 2'd3) |=> (rsp_err && !mem_rd && !mem_wr));

   // R5
   zext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && mem_size == 2'd0) |-> (rsp_data[DATA_W-1:8] == '0));

   // R5
   zext_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && mem_size == 2'd1) |-> (rsp_data[DATA_W-1:16] == '0));

   // R10
   err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_done && !mem_lock && $past(req_ready)));

   generate
      if (STRICT_ALIGN) begin : g_align_chk
         // R3
         misalign_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_ready &&
             ((req_size == 2'd1 && req_addr[0]) || (req_size == 2'd2 && req_addr[1:0] != 2'd0)))
            |=> (rsp_err && !mem_rd));
      end
   endgenerate
endmodule

// File: tb/sim_cas_unit.sv
`timescale 1ns/1ps
module sim_cas_unit;
   localparam int NV = 10;

   // columns: address, size code, compare value, new value, memory word,
   // expected response data, expected write data, expected error
   localparam logic [31:0] T_ADDR [NV] = '{32'h100, 32'h104, 32'h203, 32'h203, 32'h302,
                                           32'h302, 32'h301, 32'h102, 32'h100, 32'h007};
   localparam logic [1:0]  T_SIZE [NV] = '{2'd2, 2'd2, 2'd0, 2'd0, 2'd1,
                                           2'd1, 2'd1, 2'd2, 2'd3, 2'd0};
   localparam logic [31:0] T_CMP  [NV] = '{32'h12345678, 32'h11111111, 32'h000000A5, 32'h100000A5,
                                           32'h0000BEEF, 32'h0000BEEE, 32'h0, 32'h0, 32'h0, 32'h0};
   localparam logic [31:0] T_NEW  [NV] = '{32'hCAFEF00D, 32'h22222222, 32'hFFFFFF3C, 32'hFFFFFF3C,
                                           32'h87654321, 32'h87654321, 32'h1, 32'h1, 32'h1, 32'h000001FF};
   localparam logic [31:0] T_MEM  [NV] = '{32'h12345678, 32'h33333333, 32'hDEADBEA5, 32'hDEADBEA5,
                                           32'h1234BEEF, 32'hFFFFBEEF, 32'h5, 32'h5, 32'h5, 32'hABCDEF00};
   localparam logic [31:0] T_RSP  [NV] = '{32'h12345678, 32'h33333333, 32'h000000A5, 32'h000000A5,
                                           32'h0000BEEF, 32'h0000BEEF, 32'h0, 32'h0, 32'h0, 32'h0};
   localparam logic [31:0] T_WDAT [NV] = '{32'hCAFEF00D, 32'h33333333, 32'h0000003C, 32'h000000A5,
                                           32'h00004321, 32'h0000BEEF, 32'h0, 32'h0, 32'h0, 32'h000000FF};
   localparam logic        T_ERR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_cmp = '0;
   logic [31:0] req_new = '0;
   logic        rsp_done, rsp_err;
   logic [31:0] rsp_data;
   logic        mem_rd, mem_wr, mem_lock;
   logic [31:0] mem_addr;
   logic [1:0]  mem_size;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        mem_ack;

   logic [31:0] mem_word = '0;
   int          rd_cnt, wr_cnt, lock_bad;
   logic [31:0] rd_addr, wr_addr, wr_data;
   logic [1:0]  rd_size, wr_size;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   cas_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_size(req_size), .req_cmp(req_cmp), .req_new(req_new),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_data(rsp_data),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_lock(mem_lock), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // memory model: acknowledges one cycle after a request, returns a full word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
         rd_cnt    <= 0;
         wr_cnt    <= 0;
         rd_addr   <= '0;
         rd_size   <= '0;
         wr_addr   <= '0;
         wr_size   <= '0;
         wr_data   <= '0;
      end else if ((mem_rd || mem_wr) && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_rd) begin
            rd_cnt    <= rd_cnt + 1;
            rd_addr   <= mem_addr;
            rd_size   <= mem_size;
            mem_rdata <= mem_word;
         end
         if (mem_wr) begin
            wr_cnt  <= wr_cnt + 1;
            wr_addr <= mem_addr;
            wr_size <= mem_size;
            wr_data <= mem_wdata;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // lock monitor, sampled away from the active edge
   initial begin
      lock_bad = 0;
      forever begin
         @(negedge clk);
         if (rst_n && (mem_rd || mem_wr) && !mem_lock) lock_bad++;
         if (rst_n && req_ready && mem_lock) lock_bad++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // issue one request and wait for its response; returns response fields
   task automatic run_op(input logic [31:0] a, input logic [1:0] s, input logic [31:0] c,
                         input logic [31:0] nv, output logic got_err,
                         output logic [31:0] got_data, output bit timed_out);
      @(negedge clk);
      req_addr  = a;
      req_size  = s;
      req_cmp   = c;
      req_new   = nv;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 ready low after accept", {31'b0, req_ready}, 32'd0);
      timed_out = 1'b1;
      for (int k = 0; k < 50; k++) begin
         if (rsp_done) begin
            timed_out = 1'b0;
            break;
         end
         @(negedge clk);
      end
      got_err  = rsp_err;
      got_data = rsp_data;
      @(negedge clk);
      chk("R10 done is a single pulse", {31'b0, rsp_done}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic        e;
      logic [31:0] d;
      bit          to;
      int          r0, w0;

      repeat (3) @(negedge clk);
      // reset state (R1)
      chk("R1 ready in reset", {31'b0, req_ready}, 32'd1);
      chk("R1 no access in reset", {29'b0, mem_rd, mem_wr, mem_lock}, 32'd0);
      chk("R1 no done in reset", {31'b0, rsp_done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);

      // vector table: R2 R3 R4 R5 R6 R7 R8 R10
      for (int i = 0; i < NV; i++) begin
         mem_word = T_MEM[i];
         r0 = rd_cnt;
         w0 = wr_cnt;
         run_op(T_ADDR[i], T_SIZE[i], T_CMP[i], T_NEW[i], e, d, to);
         chk($sformatf("R10 response arrives v%0d", i), {31'b0, to}, 32'd0);
         chk($sformatf("R2 R3 error flag v%0d", i), {31'b0, e}, {31'b0, T_ERR[i]});
         chk($sformatf("R5 response data v%0d", i), d, T_RSP[i]);
         if (T_ERR[i]) begin
            chk($sformatf("R3 no read on reject v%0d", i), rd_cnt - r0, 32'd0);
            chk($sformatf("R2 no write on reject v%0d", i), wr_cnt - w0, 32'd0);
         end else begin
            chk($sformatf("R4 one read v%0d", i), rd_cnt - r0, 32'd1);
            chk($sformatf("R4 one write v%0d", i), wr_cnt - w0, 32'd1);
            chk($sformatf("R4 read address v%0d", i), rd_addr, T_ADDR[i]);
            chk($sformatf("R4 write address v%0d", i), wr_addr, T_ADDR[i]);
            chk($sformatf("R4 read size v%0d", i), {30'b0, rd_size}, {30'b0, T_SIZE[i]});
            chk($sformatf("R4 write size v%0d", i), {30'b0, wr_size}, {30'b0, T_SIZE[i]});
            chk($sformatf("R6 R7 R8 write data v%0d", i), wr_data, T_WDAT[i]);
         end
      end

      // reset in the middle of an operation (R1, R9)
      mem_word = 32'h0;
      @(negedge clk);
      req_addr = 32'h40; req_size = 2'd2; req_cmp = 32'h0; req_new = 32'h9;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R9 lock held during read", {31'b0, mem_lock}, 32'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 ready after mid-op reset", {31'b0, req_ready}, 32'd1);
      chk("R9 lock released by reset", {29'b0, mem_rd, mem_wr, mem_lock}, 32'd0);
      rst_n = 1'b1;

      // recovery: word compare with match after reset (R7)
      mem_word = 32'h0000_0000;
      run_op(32'h44, 2'd2, 32'h0, 32'hA5A5_5A5A, e, d, to);
      chk("R7 recovery write data", wr_data, 32'hA5A5_5A5A);
      chk("R10 recovery error flag", {31'b0, e}, 32'd0);

      // lock monitor summary (R9)
      chk("R9 lock covers every access", lock_bad, 32'd0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule